// File: doc/BRIEF.md
# SECDED Codec for 32-bit Words

This block guards a 32-bit word with an extended Hamming code. It can correct any single flipped bit and detect any two flipped bits. The encoder takes a data word and builds a 40-bit stored word. That word holds 32 data bits, six check bits, one whole-word parity bit and one padding bit that is always zero. The decoder takes a 40-bit word read back from storage. It returns the repaired data, the raw syndrome, and exactly one of four verdicts: clean, repaired single error, whole-word parity bit flipped, or uncorrectable.

Both paths are combinational. A parameter selects whether one register stage is placed after them, and that stage is present by default. The encoder and the decoder run independently, so a write path and a read path can share one instance.

Top module: `secded_codec`

## Requirements
- R1: Layout of the stored word, by bit index. Index 0 holds the whole-word parity bit. Indices 1, 2, 4, 8, 16 and 32 hold check bits. Data bits 0 through 31 fill the remaining indices from 3 to 38 in ascending order. Index 39 is 0. Check bit 2^j makes even parity over every index from 1 to 38 whose bit j is set. Index 0 makes indices 0 to 38 together even. For example, data 0x00000001 encodes to 0x000000000F.
- R2: When the syndrome is zero and the whole-word parity holds, the decoder raises the clean flag and returns the data unchanged.
- R3: A single flipped bit at index 1 to 38 raises the corrected flag. The syndrome then equals that index and the data is fully restored, including when the flipped bit is a check bit.
- R4: A flip of only index 0 gives a zero syndrome with a parity mismatch. This raises the parity-bit flag, and the data is returned correct.
- R5: A non-zero syndrome with matching parity raises the uncorrectable flag. The syndrome equals the XOR of the flipped indices, and the data is extracted without modification.
- R6: A parity mismatch with a syndrome above 38 raises the uncorrectable flag, and no bit is inverted.
- R7: Index 39 of the received word has no effect on any decoder output.
- R8: Exactly one of the four verdict flags is high at any time outside reset.
- R9: With the output stage enabled, results appear one clock after their inputs. During reset the outputs read as the decode of an all-zero word: encoded word 0, data 0, syndrome 0 and clean flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 32 | Data word to encode |
| enc_code_o | output | 40 | Encoded stored word |
| dec_code_i | input | 40 | Stored word to check and repair |
| dec_data_o | output | 32 | Repaired data |
| dec_syndrome_o | output | 6 | Recomputed syndrome |
| dec_clean_o | output | 1 | No error seen |
| dec_corrected_o | output | 1 | Single error repaired |
| dec_pbit_o | output | 1 | Only the whole-word parity bit flipped |
| dec_uncorr_o | output | 1 | Uncorrectable error |

## Verification
Each input applied on a falling edge is captured by the output stage at the next rising edge. The matching encoder and decoder results are therefore due one cycle after the stimulus. The driver queues its predictions at the same falling edge, and the monitor pops one prediction 2 ns after each rising edge. This makes every comparison fall in the cycle where the result first appears and never in the cycle where it is driven. The reset values are checked separately while reset is still asserted.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [1:0] {
      CLS_CLEAN = 2'd0,
      CLS_FIXED = 2'd1,
      CLS_PBIT  = 2'd2,
      CLS_FATAL = 2'd3
   } secded_cls_e;

   // True when q is a power of two (check-bit slot).
   function automatic bit is_pow2(input int unsigned q);
      return (q != 0) && ((q & (q - 1)) == 0);
   endfunction

   // Codeword index that carries data bit k.
   function automatic int unsigned data_pos(input int unsigned k);
      int unsigned seen;
      int unsigned pos;
      bit          found;
      seen  = 0;
      pos   = 0;
      found = 1'b0;
      for (int unsigned q = 1; q < 1024; q++) begin
         if (!found && !is_pow2(q)) begin
            if (seen == k) begin
               pos   = q;
               found = 1'b1;
            end
            seen++;
         end
      end
      return pos;
   endfunction

endpackage

// File: rtl/secded_parity_tree.sv
module secded_parity_tree #(
   parameter int LAST_POS = 38,
   parameter int CHK_W    = 6
) (
   input  logic [LAST_POS:1] vec_i,
   output logic [CHK_W-1:0]  syn_o
);
   always_comb begin
      syn_o = '0;
      for (int p = 1; p <= LAST_POS; p++) begin
         for (int j = 0; j < CHK_W; j++) begin
            if (((p >> j) & 1) != 0) syn_o[j] = syn_o[j] ^ vec_i[p];
         end
      end
   end
endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 6,
   parameter int CODE_W = 40
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o
);
   localparam int LAST_POS = DATA_W + CHK_W;
   localparam int SPARE_W  = CODE_W - LAST_POS - 1;

   logic [LAST_POS:1] spread;
   logic [LAST_POS:1] full;
   logic [CHK_W-1:0]  chk;

   for (genvar k = 0; k < DATA_W; k++) begin : g_place
      localparam int unsigned POS = secded_pkg::data_pos(k);
      assign spread[POS] = data_i[k];
   end
   for (genvar j = 0; j < CHK_W; j++) begin : g_hole
      assign spread[1 << j] = 1'b0;
   end

   secded_parity_tree #(.LAST_POS(LAST_POS), .CHK_W(CHK_W)) u_tree (
      .vec_i (spread),
      .syn_o (chk)
   );

   always_comb begin
      full = spread;
      for (int j = 0; j < CHK_W; j++) full[1 << j] = chk[j];
   end

   if (SPARE_W > 0) begin : g_pad
      assign code_o = {{SPARE_W{1'b0}}, full, ^full};
   end else begin : g_nopad
      assign code_o = {full, ^full};
   end
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 6,
   parameter int CODE_W = 40
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] data_o,
   output logic [CHK_W-1:0]  syn_o,
   output secded_pkg::secded_cls_e cls_o
);
   import secded_pkg::*;

   localparam int LAST_POS = DATA_W + CHK_W;
   localparam logic [CHK_W-1:0] LAST_SYN = CHK_W'(LAST_POS);

   logic [LAST_POS:1] body;
   logic [LAST_POS:1] flip;
   logic [LAST_POS:1] fixed_body;
   logic              par_err;
   logic              fix_en;

   assign body    = code_i[LAST_POS:1];
   assign par_err = ^code_i[LAST_POS:0];

   secded_parity_tree #(.LAST_POS(LAST_POS), .CHK_W(CHK_W)) u_tree (
      .vec_i (body),
      .syn_o (syn_o)
   );

   // Four-rule sort on syndrome zero/non-zero and parity match.
   always_comb begin
      if (syn_o == '0) begin
         cls_o = par_err ? CLS_PBIT : CLS_CLEAN;
      end else if (par_err && (syn_o <= LAST_SYN)) begin
         cls_o = CLS_FIXED;
      end else begin
         cls_o = CLS_FATAL;
      end
   end

   assign fix_en = (cls_o == CLS_FIXED);

   always_comb begin
      for (int p = 1; p <= LAST_POS; p++) begin
         flip[p] = fix_en && (syn_o == CHK_W'(p));
      end
   end

   assign fixed_body = body ^ flip;

   for (genvar k = 0; k < DATA_W; k++) begin : g_pick
      localparam int unsigned POS = data_pos(k);
      assign data_o[k] = fixed_body[POS];
   end
endmodule

// File: rtl/secded_pipe.sv
module secded_pipe #(
   parameter int           W       = 8,
   parameter bit           REG_OUT = 1'b1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o <= RST_VAL;
         else        q_o <= d_i;
      end
   end else begin : g_wire
      assign q_o = d_i;
   end
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
   parameter int DATA_W  = 32,
   parameter int CHK_W   = 6,
   parameter int CODE_W  = 40,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] enc_data_i,
   output logic [CODE_W-1:0] enc_code_o,
   input  logic [CODE_W-1:0] dec_code_i,
   output logic [DATA_W-1:0] dec_data_o,
   output logic [CHK_W-1:0]  dec_syndrome_o,
   output logic              dec_clean_o,
   output logic              dec_corrected_o,
   output logic              dec_pbit_o,
   output logic              dec_uncorr_o
);
   import secded_pkg::*;

   localparam int LAST_POS = DATA_W + CHK_W;
   localparam int DEC_W    = DATA_W + CHK_W + 4;
   localparam logic [DEC_W-1:0] DEC_RST = {{(DATA_W + CHK_W){1'b0}}, 4'b1000};

   if ((1 << CHK_W) < LAST_POS + 1) begin : g_chk_bad
      $error("CHK_W too small for DATA_W");
   end
   if (CODE_W < LAST_POS + 1) begin : g_code_bad
      $error("CODE_W too small to hold the code");
   end

   logic [CODE_W-1:0] enc_raw;
   logic [DATA_W-1:0] dec_data_raw;
   logic [CHK_W-1:0]  dec_syn_raw;
   secded_cls_e       dec_cls;
   logic [3:0]        flag_raw;
   logic [DEC_W-1:0]  dec_bus;

   secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_enc (
      .data_i (enc_data_i),
      .code_o (enc_raw)
   );

   secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_dec (
      .code_i (dec_code_i),
      .data_o (dec_data_raw),
      .syn_o  (dec_syn_raw),
      .cls_o  (dec_cls)
   );

   assign flag_raw = {dec_cls == CLS_CLEAN, dec_cls == CLS_FIXED,
                      dec_cls == CLS_PBIT,  dec_cls == CLS_FATAL};

   secded_pipe #(.W(CODE_W), .REG_OUT(REG_OUT), .RST_VAL('0)) u_enc_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (enc_raw),
      .q_o   (enc_code_o)
   );

   secded_pipe #(.W(DEC_W), .REG_OUT(REG_OUT), .RST_VAL(DEC_RST)) u_dec_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({dec_data_raw, dec_syn_raw, flag_raw}),
      .q_o   (dec_bus)
   );

   assign dec_data_o      = dec_bus[DEC_W-1 -: DATA_W];
   assign dec_syndrome_o  = dec_bus[4 +: CHK_W];
   assign dec_clean_o     = dec_bus[3];
   assign dec_corrected_o = dec_bus[2];
   assign dec_pbit_o      = dec_bus[1];
   assign dec_uncorr_o    = dec_bus[0];
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
   parameter int CHK_W    = 6,
   parameter int CODE_W   = 40,
   parameter int LAST_POS = 38
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] enc_code_o,
   input logic [CHK_W-1:0]  dec_syndrome_o,
   input logic              dec_clean_o,
   input logic              dec_corrected_o,
   input logic              dec_pbit_o,
   input logic              dec_uncorr_o
);
   localparam logic [CHK_W-1:0] LAST_SYN = CHK_W'(LAST_POS);

   // R8
   a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({dec_clean_o, dec_corrected_o, dec_pbit_o, dec_uncorr_o}) == 1);

   // R2
   a_r2_clean_zero_syn: assert property (@(posedge clk) disable iff (!rst_n)
      dec_clean_o |-> dec_syndrome_o == '0);

   // R3
   a_r3_fix_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      dec_corrected_o |-> (dec_syndrome_o != '0) && (dec_syndrome_o <= LAST_SYN));

   // R4
   a_r4_pbit_zero_syn: assert property (@(posedge clk) disable iff (!rst_n)
      dec_pbit_o |-> dec_syndrome_o == '0);

   // R5
   a_r5_fatal_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      dec_uncorr_o |-> dec_syndrome_o != '0);

   // R6
   a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_syndrome_o > LAST_SYN) |-> dec_uncorr_o);

   // R1
   a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      enc_code_o[CODE_W-1:LAST_POS+1] == '0);

   // R1
   a_r1_even_word: assert property (@(posedge clk) disable iff (!rst_n)
      (^enc_code_o[LAST_POS:0]) == 1'b0);
endmodule

bind secded_codec secded_codec_chk #(
   .CHK_W(CHK_W), .CODE_W(CODE_W), .LAST_POS(LAST_POS)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .enc_code_o      (enc_code_o),
   .dec_syndrome_o  (dec_syndrome_o),
   .dec_clean_o     (dec_clean_o),
   .dec_corrected_o (dec_corrected_o),
   .dec_pbit_o      (dec_pbit_o),
   .dec_uncorr_o    (dec_uncorr_o)
);

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb;

   typedef struct {
      logic [39:0] code;
      logic [31:0] data;
      logic [5:0]  syn;
      logic [3:0]  flags;   // {clean, corrected, pbit, uncorr}
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] enc_data_i = '0;
   logic [39:0] enc_code_o;
   logic [39:0] dec_code_i = '0;
   logic [31:0] dec_data_o;
   logic [5:0]  dec_syndrome_o;
   logic        dec_clean_o, dec_corrected_o, dec_pbit_o, dec_uncorr_o;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   secded_codec u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .enc_data_i      (enc_data_i),
      .enc_code_o      (enc_code_o),
      .dec_code_i      (dec_code_i),
      .dec_data_o      (dec_data_o),
      .dec_syndrome_o  (dec_syndrome_o),
      .dec_clean_o     (dec_clean_o),
      .dec_corrected_o (dec_corrected_o),
      .dec_pbit_o      (dec_pbit_o),
      .dec_uncorr_o    (dec_uncorr_o)
   );

   function automatic bit pow2(input int p);
      return (p != 0) && ((p & (p - 1)) == 0);
   endfunction

   function automatic logic [39:0] ref_encode(input logic [31:0] d);
      logic [39:0] c;
      int          k;
      logic        par;
      c = '0;
      k = 0;
      for (int p = 1; p <= 38; p++) begin
         if (!pow2(p)) begin
            c[p] = d[k];
            k++;
         end
      end
      for (int j = 0; j < 6; j++) begin
         par = 1'b0;
         for (int p = 1; p <= 38; p++) if (((p >> j) & 1) != 0) par ^= c[p];
         c[1 << j] = par;
      end
      c[0] = ^c[38:1];
      return c;
   endfunction

   function automatic logic [31:0] ref_extract(input logic [39:0] c);
      logic [31:0] d;
      int          k;
      d = '0;
      k = 0;
      for (int p = 1; p <= 38; p++) begin
         if (!pow2(p)) begin
            d[k] = c[p];
            k++;
         end
      end
      return d;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Driver: applies one word to both paths and queues the prediction.
   task automatic drive(input logic [31:0] d, input logic [39:0] flips, input string req);
      exp_t        e;
      logic [39:0] good;
      logic [5:0]  syn;
      bit          parbad;
      good   = ref_encode(d);
      syn    = '0;
      for (int p = 1; p <= 38; p++) if (flips[p]) syn ^= 6'(p);
      parbad = ^flips[38:0];
      e.code = good;
      e.syn  = syn;
      e.req  = req;
      e.data = d;
      if (syn == 0 && !parbad)              e.flags = 4'b1000;
      else if (syn == 0)                    e.flags = 4'b0010;
      else if (parbad && syn <= 6'd38)      e.flags = 4'b0100;
      else begin
         e.flags = 4'b0001;
         e.data  = ref_extract(good ^ flips);
      end
      @(negedge clk);
      enc_data_i = d;
      dec_code_i = good ^ flips;
      sb_q.push_back(e);
   endtask

   // Monitor: one prediction is due one clock after it was driven.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            exp_t e;
            logic [3:0] f;
            e = sb_q.pop_front();
            f = {dec_clean_o, dec_corrected_o, dec_pbit_o, dec_uncorr_o};
            check(enc_code_o == e.code, "R1", "encoded word", 64'(enc_code_o), 64'(e.code));
            check(dec_data_o == e.data, e.req, "data", 64'(dec_data_o), 64'(e.data));
            check(dec_syndrome_o == e.syn, e.req, "syndrome", 64'(dec_syndrome_o), 64'(e.syn));
            check(f == e.flags, {e.req, " R8"}, "flags", 64'(f), 64'(e.flags));
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check(enc_code_o == '0, "R9", "reset code", 64'(enc_code_o), 64'h0);
      check(dec_data_o == '0 && dec_syndrome_o == '0, "R9", "reset data/syn",
            64'({dec_data_o, dec_syndrome_o}), 64'h0);
      check({dec_clean_o, dec_corrected_o, dec_pbit_o, dec_uncorr_o} == 4'b1000, "R9",
            "reset flags", 64'({dec_clean_o, dec_corrected_o, dec_pbit_o, dec_uncorr_o}), 64'h8);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 literal encode of data 1, then R2 clean words (R9 latency throughout)
      drive(32'h0000_0001, '0, "R2");
      @(posedge clk); #2;
      check(enc_code_o == 40'h00_0000_000F, "R1", "literal encode", 64'(enc_code_o), 64'hF);
      drive(32'h0000_0000, '0, "R2");
      drive(32'hFFFF_FFFF, '0, "R2");
      drive(32'hA5A5_A5A5, '0, "R2");
      drive(32'hDEAD_BEEF, '0, "R2");

      // R3: every single position, data and check bits alike
      for (int p = 1; p <= 38; p++) drive(32'hDEAD_BEEF, 40'(1) << p, "R3");
      drive(32'h1234_5678, 40'(1) << 16, "R3");

      // R4: only the whole-word parity bit
      drive(32'hCAFE_F00D, 40'h1, "R4");

      // R7: padding bit flipped, alone and with a single error
      drive(32'h0F0F_0F0F, 40'(1) << 39, "R7");
      drive(32'h0F0F_0F0F, (40'(1) << 39) | (40'(1) << 9), "R7");

      // R5: double errors
      drive(32'h8765_4321, (40'(1) << 3) | (40'(1) << 5), "R5");
      drive(32'h8765_4321, (40'(1) << 1) | (40'(1) << 38), "R5");
      drive(32'hFFFF_FFFF, (40'(1) << 16) | (40'(1) << 32), "R5");

      // R6: odd flips whose syndrome points past index 38
      drive(32'h5555_AAAA, (40'(1) << 32) | (40'(1) << 4) | (40'(1) << 3), "R6");
      drive(32'h5555_AAAA, (40'(1) << 38) | (40'(1) << 1) | 40'h1, "R6");

      drive(32'h0, '0, "R2");
      repeat (4) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule